// File: doc/BRIEF.md
# Multicore Synchronous Halt Matrix

This block links the debug halt signals of a group of cores so that they stop together and resume together. Every core reports whether it is halted on a halt-status line into the matrix. The matrix returns to each core a halt request line and a resume pulse line. When one core enters halt, every other core that has chosen to follow it gets a halt request on the same clock edge. When a followed core leaves halt, its followers get a one-cycle resume pulse.

Each core owns two configuration words on a simple valid/write/address/data bus. The halt-follow word selects the cores whose halt this core copies. The resume-follow word selects the cores whose resume this core copies. After reset both words are zero, so every core runs on its own. Bit positions in both words are core numbers. A core's bit for itself has no effect, so a core can never trigger itself.

The status inputs are taken to be synchronous to the matrix clock. The core count is a parameter from 2 to 8.

Top module: `coresync_matrix`

## Requirements
- R1: After reset all configuration words read zero and every halt request and resume pulse output is low.
- R2: A rising edge on core j's halt status drives halt request i high one cycle later when bit j of core i's halt-follow word is set, j differs from i, and core i is not halted. Every core so selected sees its request in that same cycle.
- R3: A halt request, once high, stays high until the target core's own halt status is high. It goes low on the edge after that status is seen.
- R4: Bit i of core i's halt-follow word and bit i of its resume-follow word have no effect on core i's outputs.
- R5: A falling edge on core j's halt status produces a one-cycle resume pulse to core i on the next cycle when bit j of core i's resume-follow word is set and j differs from i.
- R6: Byte address 4*i holds core i's halt-follow word and byte address 4*N+4*i holds its resume-follow word. Only data bits N-1..0 are stored, and reads return zero above bit N-1.
- R7: A read of an address that is not mapped (an address not a multiple of 4, or an address of 8*N or more) returns zero, and a write to such an address changes no word.
- R8: A core whose follow words are zero never receives a halt request or resume pulse, whatever the other cores do.
- R9: The read data output is zero in any cycle without a read. During a read it shows the addressed word in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Matrix clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_stat_i | input | NCORE | Per-core halt status, high while halted |
| halt_req_o | output | NCORE | Per-core halt request, held until the core halts |
| resume_pls_o | output | NCORE | Per-core one-cycle resume pulse |
| cfg_valid_i | input | 1 | Configuration access valid |
| cfg_write_i | input | 1 | 1 = write, 0 = read |
| cfg_addr_i | input | AW | Byte address |
| cfg_wdata_i | input | DW | Write data |
| cfg_rdata_o | output | DW | Read data, valid in the cycle of the read |

## Verification
Suppose an edge register holds a wrong previous status. The error shows one cycle later as a halt request or resume pulse that appears, or is missing, on every follower of that core. A halt request that is cleared too early or held too long shows at the request port on the very next edge. That makes it visible when compared with the target's own status. A corrupted configuration word shows at once on a read-back. It also shows at the outputs on the first edge that the word selects, so the table walk covers the stored words as well as the routing.

// File: rtl/csm_pkg.sv
`timescale 1ns/1ps
package csm_pkg;

  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_HALT  = 2'd1,
    SLOT_RESUM = 2'd2
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic [7:0] core;
  } slot_t;

  // Byte address to configuration slot: halt words first, resume words after.
  function automatic slot_t decode_addr(input logic [31:0] a, input int unsigned ncore);
    slot_t       s;
    int unsigned w;
    s.kind = SLOT_NONE;
    s.core = 8'd0;
    w      = {2'b00, a[31:2]};
    if (a[1:0] == 2'b00) begin
      if (w < ncore) begin
        s.kind = SLOT_HALT;
        s.core = w[7:0];
      end else if (w < 2 * ncore) begin
        s.kind = SLOT_RESUM;
        s.core = 8'(w - ncore);
      end
    end
    return s;
  endfunction

  // Any selected event present.
  function automatic logic any_hit(input logic [7:0] ev, input logic [7:0] sel);
    return |(ev & sel);
  endfunction

  // Next state of a sticky halt request.
  function automatic logic next_halt_req(input logic held, input logic hit,
                                         input logic halted);
    return ~halted & (held | hit);
  endfunction

endpackage

// File: rtl/csm_edge_detect.sv
`timescale 1ns/1ps
module csm_edge_detect #(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] stat_i,
  output logic [NCORE-1:0] rise_o,
  output logic [NCORE-1:0] fall_o
);

  logic [NCORE-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stat_i;
  end

  assign rise_o = stat_i & ~prev_q;
  assign fall_o = ~stat_i & prev_q;

  // R2
  rise_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

  // R5
  fall_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));

endmodule

// File: rtl/csm_regfile.sv
`timescale 1ns/1ps
module csm_regfile
  import csm_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  logic                   write_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NCORE*NCORE-1:0] halt_sel_o,
  output logic [NCORE*NCORE-1:0] resum_sel_o
);

  localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1;

  slot_t                  slot;
  logic [IW-1:0]          idx;
  logic                   wr_halt, wr_resum, wr_unmapped;
  logic [NCORE*NCORE-1:0] halt_q, resum_q;

  assign slot        = decode_addr(32'(addr_i), unsigned'(NCORE));
  assign idx         = slot.core[IW-1:0];
  assign wr_halt     = valid_i & write_i & (slot.kind == SLOT_HALT);
  assign wr_resum    = valid_i & write_i & (slot.kind == SLOT_RESUM);
  assign wr_unmapped = valid_i & write_i & (slot.kind == SLOT_NONE);

  for (genvar k = 0; k < NCORE; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        halt_q[k*NCORE +: NCORE]  <= '0;
        resum_q[k*NCORE +: NCORE] <= '0;
      end else begin
        if (wr_halt && idx == IW'(k))
          halt_q[k*NCORE +: NCORE] <= wdata_i[NCORE-1:0];
        if (wr_resum && idx == IW'(k))
          resum_q[k*NCORE +: NCORE] <= wdata_i[NCORE-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (valid_i && !write_i) begin
      case (slot.kind)
        SLOT_HALT:  rdata_o[NCORE-1:0] = halt_q[idx*NCORE +: NCORE];
        SLOT_RESUM: rdata_o[NCORE-1:0] = resum_q[idx*NCORE +: NCORE];
        default:    rdata_o = '0;
      endcase
    end
  end

  assign halt_sel_o  = halt_q;
  assign resum_sel_o = resum_q;

  // R7
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> ($stable(halt_q) && $stable(resum_q)));

  // R6
  halt_word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_halt |=> (halt_q[$past(idx)*NCORE +: NCORE] == $past(wdata_i[NCORE-1:0])));

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (rdata_o == '0));

endmodule

// File: rtl/csm_route.sv
`timescale 1ns/1ps
module csm_route
  import csm_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int SELF  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             own_stat_i,
  input  logic [NCORE-1:0] rise_i,
  input  logic [NCORE-1:0] fall_i,
  input  logic [NCORE-1:0] halt_sel_i,
  input  logic [NCORE-1:0] resum_sel_i,
  output logic             halt_req_o,
  output logic             resume_pls_o
);

  localparam logic [NCORE-1:0] SELF_ONE = NCORE'(1) << SELF;

  logic [NCORE-1:0] halt_eff, resum_eff;
  logic             halt_hit, resum_hit;

  assign halt_eff  = halt_sel_i  & ~SELF_ONE;
  assign resum_eff = resum_sel_i & ~SELF_ONE;
  assign halt_hit  = any_hit(8'(rise_i), 8'(halt_eff));
  assign resum_hit = any_hit(8'(fall_i), 8'(resum_eff));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req_o   <= 1'b0;
      resume_pls_o <= 1'b0;
    end else begin
      halt_req_o   <= next_halt_req(halt_req_o, halt_hit, own_stat_i);
      resume_pls_o <= resum_hit;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req_o && !own_stat_i) |=> halt_req_o);

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_stat_i |=> !halt_req_o);

  // R2
  req_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req_o) |-> ($past(rise_i & ~SELF_ONE) != '0));

  // R4
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i == SELF_ONE && !halt_req_o) |=> !halt_req_o);

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pls_o |-> ($past(fall_i & ~SELF_ONE) != '0));

endmodule

// File: rtl/coresync_matrix.sv
`timescale 1ns/1ps
module coresync_matrix #(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] halt_stat_i,
  output logic [NCORE-1:0] halt_req_o,
  output logic [NCORE-1:0] resume_pls_o,
  input  logic             cfg_valid_i,
  input  logic             cfg_write_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic [DW-1:0]    cfg_rdata_o
);

  logic [NCORE-1:0]       stat_rise, stat_fall;
  logic [NCORE*NCORE-1:0] halt_sel, resum_sel;

  csm_edge_detect #(.NCORE(NCORE)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (halt_stat_i),
    .rise_o (stat_rise),
    .fall_o (stat_fall)
  );

  csm_regfile #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (cfg_valid_i),
    .write_i     (cfg_write_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .halt_sel_o  (halt_sel),
    .resum_sel_o (resum_sel)
  );

  for (genvar i = 0; i < NCORE; i++) begin : g_tgt
    csm_route #(.NCORE(NCORE), .SELF(i)) u_route (
      .clk          (clk),
      .rst_n        (rst_n),
      .own_stat_i   (halt_stat_i[i]),
      .rise_i       (stat_rise),
      .fall_i       (stat_fall),
      .halt_sel_i   (halt_sel[i*NCORE +: NCORE]),
      .resum_sel_i  (resum_sel[i*NCORE +: NCORE]),
      .halt_req_o   (halt_req_o[i]),
      .resume_pls_o (resume_pls_o[i])
    );
  end

  // R8
  quiet_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_sel[NCORE-1:0] == '0 && resum_sel[NCORE-1:0] == '0 && !halt_req_o[0])
      |=> (!halt_req_o[0] && !resume_pls_o[0]));

endmodule

// File: tb/coresync_matrix_tb_top.sv
`timescale 1ns/1ps
module coresync_matrix_tb_top;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  halt_stat = '0;
  logic [N-1:0]  halt_req, resume_pls;
  logic          cfg_valid = 1'b0, cfg_write = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0, cfg_rdata;
  int            checks = 0, failures = 0;

  always #5 clk = ~clk;

  coresync_matrix #(.NCORE(N), .AW(8), .DW(32)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_stat_i  (halt_stat),
    .halt_req_o   (halt_req),
    .resume_pls_o (resume_pls),
    .cfg_valid_i  (cfg_valid),
    .cfg_write_i  (cfg_write),
    .cfg_addr_i   (cfg_addr),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_rdata_o  (cfg_rdata)
  );

  // Each entry: {halt status applied, expected halt_req, expected resume_pls}.
  // Halt-follow: c0=0010 c1=0000 c2=0011 c3=1111; resume-follow: c0=0010 c1=0000 c2=0001 c3=1000.
  localparam logic [11:0] VEC [14] = '{
    12'h000, // idle
    12'h2D0, // c1 halts: c0,c2,c3 requested together (R2, R8 c1 quiet)
    12'h2D0, // requests held (R3)
    12'hF00, // all halted: requests drop (R3)
    12'hD01, // c1 resumes: pulse to c0 (R5)
    12'h004, // c0,c2,c3 resume: pulse to c2 only, c3 self ignored (R4)
    12'h000, // pulse lasts one cycle (R5)
    12'h800, // c3 halts, only its own bit selects it (R4)
    12'h940, // c0 halts: c2 requested, c3 already halted
    12'h940, // held
    12'h140, // c3 resumes: self resume bit ignored (R4)
    12'h580, // c2 halts: its request drops, c3 requested
    12'hD00, // c3 halts
    12'h004  // all resume: pulse to c2
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_valid = 1'b0; cfg_write = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = a;
    #1;
    d = cfg_rdata;
    cfg_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 halt_req after reset", 32'(halt_req), 32'h0);
    chk("R1 resume_pls after reset", 32'(resume_pls), 32'h0);
    for (int k = 0; k < 2 * N; k++) begin
      rd(8'(4 * k), d);
      chk("R1 word after reset", d, 32'h0);
    end

    // R9 idle read data
    cfg_addr = 8'h08;
    #1 chk("R9 rdata idle", cfg_rdata, 32'h0);

    // Program the follow words (R6 map)
    wr(8'h00, 32'h2); wr(8'h04, 32'h0); wr(8'h08, 32'h3); wr(8'h0C, 32'hF);
    wr(8'h10, 32'h2); wr(8'h14, 32'h0); wr(8'h18, 32'h1); wr(8'h1C, 32'h8);
    rd(8'h08, d); chk("R6 halt word c2", d, 32'h3);
    rd(8'h18, d); chk("R6 resume word c2", d, 32'h1);

    // Table walk (R2 R3 R4 R5 R8)
    for (int k = 0; k < 14; k++) begin
      halt_stat = VEC[k][11:8];
      tick();
      chk($sformatf("R2 R3 R8 halt_req row %0d", k), 32'(halt_req), 32'(VEC[k][7:4]));
      chk($sformatf("R4 R5 resume_pls row %0d", k), 32'(resume_pls), 32'(VEC[k][3:0]));
    end

    // R6 upper data bits are not stored
    wr(8'h04, 32'hFFFF_FFF0);
    rd(8'h04, d); chk("R6 upper bits dropped", d, 32'h0);
    wr(8'h04, 32'hA5A5_A5A6);
    rd(8'h04, d); chk("R6 lower bits kept", d, 32'h6);

    // R7 unmapped accesses
    rd(8'h20, d); chk("R7 read beyond map", d, 32'h0);
    rd(8'h05, d); chk("R7 misaligned read", d, 32'h0);
    wr(8'h05, 32'hF);
    wr(8'h20, 32'hF);
    wr(8'h21, 32'hF);
    rd(8'h04, d); chk("R7 write ignored c1", d, 32'h6);
    rd(8'h00, d); chk("R7 write ignored c0", d, 32'h2);

    // R8 core with zero words stays quiet; R2 core with new word follows
    wr(8'h00, 32'h0); wr(8'h10, 32'h0);
    halt_stat = 4'b0010; tick();
    chk("R8 quiet c0 on halt", 32'(halt_req[0]), 32'h0);
    chk("R2 c1 follows c2 no", 32'(halt_req[1]), 32'h0);
    halt_stat = 4'b0000; tick();
    chk("R8 quiet c0 on resume", 32'(resume_pls[0]), 32'h0);
    halt_stat = 4'b0100; tick();
    chk("R2 c1 follows c2", 32'(halt_req[1]), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule